// File: doc/BRIEF.md
# Boost Overvoltage Fault Supervisor

This block watches the digitized output voltage of a boost power stage and shuts the stage down when that voltage has run too high for too long. Each time the sample strobe fires, the voltage code is compared with a programmable trip level. The result feeds a saturating up/down counter that works as a leaky integrator. A single overvoltage sample therefore cannot cause a trip. A fault is declared only when the count exceeds a 4-bit limit.

Once tripped, the block switches the boost stage off. It can also keep the downstream converter running with its dimming input forced to full scale, which drains charge from the bulk capacitor. The restart setting at the moment of the trip decides what happens next. In auto mode, the block returns to normal operation as soon as a sampled voltage reaches the recovery level, which depends on the line variant. In latch mode, the block stays in fault until reset.

Top module: `bovp_supervisor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, boost_en_o=1, stage2_en_o=1, dim_force_o=0 and fault_o=0.
- R2: The integrator changes only on cycles with sample_en_i=1. A sample counts as overvoltage only when vbst_i is strictly greater than ovp_thr_i, so equality counts as normal.
- R3: An overvoltage sample adds STEP (default 2) to the integrator and saturates at its maximum. A normal sample subtracts STEP and stops at zero.
- R4: In normal operation, fault_o rises and boost_en_o falls one clock after the integrator holds a value strictly greater than integ_lim_i.
- R5: While in fault, boost_en_o=0 and fault_o=1. If max_cur_en_i=1, stage2_en_o=1 and dim_force_o=1. If max_cur_en_i=0, both are 0.
- R6: If restart_en_i=1 at the trip, the fault clears on the same clock edge as a sample with vbst_i at or below the recovery level. That level is 195 when hv_variant_i=0 and 392 when hv_variant_i=1. A sample above the level keeps the fault.
- R7: If restart_en_i=0 at the trip, the fault stays until rst_ni is asserted, whatever restart_en_i and vbst_i do afterwards.
- R8: On return to normal operation, the integrator is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_en_i | input | 1 | Voltage sample strobe |
| vbst_i | input | VW | Boost output voltage code, 1 V per LSB |
| ovp_thr_i | input | VW | Overvoltage trip level code |
| integ_lim_i | input | 4 | Integrator trip limit |
| max_cur_en_i | input | 1 | Keep second stage on at full dim during fault |
| restart_en_i | input | 1 | 1: auto restart, 0: latch fault |
| hv_variant_i | input | 1 | 0: 120 V line (recover at 195), 1: 230 V line (recover at 392) |
| boost_en_o | output | 1 | Boost stage enable |
| stage2_en_o | output | 1 | Second stage enable |
| dim_force_o | output | 1 | Force second-stage dim to full scale |
| fault_o | output | 1 | Overvoltage fault active |

## Verification
The bound assertions check four things on every cycle: the integrator stays unchanged on cycles without a strobe, a count above the limit always trips the block in the next cycle, a latched fault never clears, and the integrator reads zero whenever boost comes back on. The bench scenarios cover the behaviour that needs a known history. This includes the exact number of samples to a trip, decay below the limit under alternating samples, the strict comparisons at both the trip level and the limit, and the recovery levels of each variant. It also covers the choice between latch and auto mode made at trip time, and the proof of a cleared integrator through the trip timing after a restart.

// File: rtl/bovp_pkg.sv
package bovp_pkg;
  typedef enum logic [1:0] {
    ST_RUN        = 2'd0,
    ST_TRIP_AUTO  = 2'd1,
    ST_TRIP_LATCH = 2'd2
  } sup_state_e;
endpackage

// File: rtl/bovp_level_cmp.sv
module bovp_level_cmp #(
  parameter int VW       = 10,
  parameter int RECOV_LO = 195,
  parameter int RECOV_HI = 392
) (
  input  logic [VW-1:0] vbst_i,
  input  logic [VW-1:0] thr_i,
  input  logic          hv_variant_i,
  output logic          over_o,
  output logic          recov_ok_o
);
  localparam logic [VW-1:0] LvlLo = VW'(RECOV_LO);
  localparam logic [VW-1:0] LvlHi = VW'(RECOV_HI);

  logic [VW-1:0] recov_lvl;

  assign recov_lvl  = hv_variant_i ? LvlHi : LvlLo;
  assign over_o     = vbst_i > thr_i;
  assign recov_ok_o = vbst_i <= recov_lvl;
endmodule

// File: rtl/bovp_leaky_integ.sv
module bovp_leaky_integ #(
  parameter int ACC_W = 6,
  parameter int IW    = 4,
  parameter int STEP  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             over_i,
  input  logic             clr_i,
  input  logic [IW-1:0]    lim_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             exceed_o
);
  localparam logic [ACC_W:0]   StepW  = (ACC_W+1)'(STEP);
  localparam logic [ACC_W:0]   AccMax = {1'b0, {ACC_W{1'b1}}};

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + StepW;
    acc_d = acc_q;
    if (clr_i) begin
      acc_d = '0;
    end else if (upd_i) begin
      if (over_i) begin
        acc_d = (sum > AccMax) ? AccMax[ACC_W-1:0] : sum[ACC_W-1:0];
      end else if ({1'b0, acc_q} > StepW) begin
        acc_d = acc_q - StepW[ACC_W-1:0];
      end else begin
        acc_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o    = acc_q;
  assign exceed_o = acc_q > {{(ACC_W-IW){1'b0}}, lim_i};
endmodule

// File: rtl/bovp_trip_fsm.sv
module bovp_trip_fsm
  import bovp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       exceed_i,
  input  logic       sample_en_i,
  input  logic       recov_ok_i,
  input  logic       restart_en_i,
  output sup_state_e state_o,
  output logic       clr_o
);
  sup_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    clr_o   = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (exceed_i) state_d = restart_en_i ? ST_TRIP_AUTO : ST_TRIP_LATCH;
      end
      ST_TRIP_AUTO: begin
        if (sample_en_i && recov_ok_i) begin
          state_d = ST_RUN;
          clr_o   = 1'b1;
        end
      end
      ST_TRIP_LATCH: state_d = ST_TRIP_LATCH;
      default:       state_d = ST_TRIP_LATCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/bovp_supervisor.sv
module bovp_supervisor
  import bovp_pkg::*;
#(
  parameter int VW       = 10,
  parameter int IW       = 4,
  parameter int ACC_W    = 6,
  parameter int STEP     = 2,
  parameter int RECOV_LO = 195,
  parameter int RECOV_HI = 392
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_en_i,
  input  logic [VW-1:0] vbst_i,
  input  logic [VW-1:0] ovp_thr_i,
  input  logic [IW-1:0] integ_lim_i,
  input  logic          max_cur_en_i,
  input  logic          restart_en_i,
  input  logic          hv_variant_i,
  output logic          boost_en_o,
  output logic          stage2_en_o,
  output logic          dim_force_o,
  output logic          fault_o
);
  logic             over, recov_ok, exceed, clr, running;
  logic [ACC_W-1:0] acc;
  sup_state_e       state;

  bovp_level_cmp #(.VW(VW), .RECOV_LO(RECOV_LO), .RECOV_HI(RECOV_HI)) u_cmp (
    .vbst_i       (vbst_i),
    .thr_i        (ovp_thr_i),
    .hv_variant_i (hv_variant_i),
    .over_o       (over),
    .recov_ok_o   (recov_ok)
  );

  bovp_leaky_integ #(.ACC_W(ACC_W), .IW(IW), .STEP(STEP)) u_integ (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (sample_en_i && running),
    .over_i   (over),
    .clr_i    (clr),
    .lim_i    (integ_lim_i),
    .acc_o    (acc),
    .exceed_o (exceed)
  );

  bovp_trip_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .exceed_i     (exceed),
    .sample_en_i  (sample_en_i),
    .recov_ok_i   (recov_ok),
    .restart_en_i (restart_en_i),
    .state_o      (state),
    .clr_o        (clr)
  );

  assign running     = state == ST_RUN;
  assign boost_en_o  = running;
  assign fault_o     = !running;
  assign stage2_en_o = running || max_cur_en_i;
  assign dim_force_o = !running && max_cur_en_i;
endmodule

// File: rtl/bovp_supervisor_chk.sv
module bovp_supervisor_chk
  import bovp_pkg::*;
#(
  parameter int IW    = 4,
  parameter int ACC_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sample_en_i,
  input logic [IW-1:0]    integ_lim_i,
  input logic             boost_en_o,
  input logic             fault_o,
  input logic [ACC_W-1:0] acc_i,
  input sup_state_e       state_i
);
  AST_ACC_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en_i |=> $stable(acc_i)); // R2

  AST_TRIP_ABOVE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boost_en_o && acc_i > {{(ACC_W-IW){1'b0}}, integ_lim_i}) |=> fault_o); // R4

  AST_LATCH_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_TRIP_LATCH) |=> (state_i == ST_TRIP_LATCH)); // R7

  AST_RESUME_ACC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(boost_en_o) |-> (acc_i == '0)); // R8
endmodule

bind bovp_supervisor bovp_supervisor_chk #(.IW(IW), .ACC_W(ACC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sample_en_i (sample_en_i),
  .integ_lim_i (integ_lim_i),
  .boost_en_o  (boost_en_o),
  .fault_o     (fault_o),
  .acc_i       (acc),
  .state_i     (state)
);

// File: tb/bovp_supervisor_tb.sv
module bovp_supervisor_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sample_en_i = 1'b0;
  logic [9:0] vbst_i = '0;
  logic [9:0] ovp_thr_i = 10'd240;
  logic [3:0] integ_lim_i = 4'd3;
  logic       max_cur_en_i = 1'b0;
  logic       restart_en_i = 1'b0;
  logic       hv_variant_i = 1'b0;
  logic       boost_en_o, stage2_en_o, dim_force_o, fault_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #4 clk_i = ~clk_i;

  bovp_supervisor u_dut (
    .clk_i, .rst_ni, .sample_en_i, .vbst_i, .ovp_thr_i, .integ_lim_i,
    .max_cur_en_i, .restart_en_i, .hv_variant_i,
    .boost_en_o, .stage2_en_o, .dim_force_o, .fault_o
  );

  // {vbst, expected fault after the sample and one more edge}; thr 240, lim 3
  localparam logic [10:0] VEC [6] = '{
    {10'd250, 1'b0}, {10'd230, 1'b0}, {10'd250, 1'b0},
    {10'd240, 1'b0}, {10'd250, 1'b0}, {10'd250, 1'b1}
  };

  // packed {boost, stage2, dim, fault}
  localparam logic [3:0] O_RUN    = 4'b1100;
  localparam logic [3:0] O_BLEED  = 4'b0111;
  localparam logic [3:0] O_OFF    = 4'b0001;

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {boost_en_o, stage2_en_o, dim_force_o, fault_o};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic sample(input logic [9:0] v);
    vbst_i = v;
    sample_en_i = 1'b1;
    @(negedge clk_i);
    sample_en_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(1);
    check("R1 in reset", O_RUN);
    rst_ni = 1'b1;
    idle(1);
    check("R1 after reset", O_RUN);

    // R2 R3 R4: vector walk, latch mode, no bleed
    for (int i = 0; i < 6; i++) begin
      sample(VEC[i][10:1]);
      idle(1);
      check("R3 R4 vector", VEC[i][0] ? O_OFF : O_RUN);
    end
    check("R5 fault without bleed", O_OFF);

    // R7: latched even when restart enabled and voltage low
    restart_en_i = 1'b1;
    sample(10'd100);
    idle(3);
    check("R7 latch holds", O_OFF);
    do_reset();
    check("R7 cleared by reset", O_RUN);

    // R2: no strobe, high voltage, no trip
    vbst_i = 10'd600;
    idle(20);
    check("R2 no strobe no effect", O_RUN);

    // R4 strict limit: lim 4, two overs -> 4, not above
    integ_lim_i = 4'd4;
    max_cur_en_i = 1'b1;
    sample(10'd300);
    sample(10'd300);
    idle(2);
    check("R4 at limit no trip", O_RUN);
    sample(10'd300);
    idle(1);
    check("R5 bleed mode", O_BLEED);

    // R6 variant 0 recovery at 195
    sample(10'd196);
    idle(1);
    check("R6 above recovery stays", O_BLEED);
    sample(10'd195);
    check("R6 recover at 195", O_RUN);

    // R8: cleared integrator, one over with lim 1 -> 2 > 1 trips; with lim 3 must not
    integ_lim_i = 4'd3;
    sample(10'd300);
    idle(2);
    check("R8 integrator cleared", O_RUN);
    sample(10'd100);

    // R6 variant 1 recovery at 392
    hv_variant_i = 1'b1;
    ovp_thr_i = 10'd450;
    integ_lim_i = 4'd0;
    max_cur_en_i = 1'b0;
    sample(10'd460);
    idle(1);
    check("R5 variant1 trip", O_OFF);
    sample(10'd393);
    idle(1);
    check("R6 variant1 above", O_OFF);
    sample(10'd392);
    check("R6 variant1 recover", O_RUN);

    // R3 floor at zero: many normal samples then two overs with lim 3
    integ_lim_i = 4'd3;
    for (int i = 0; i < 5; i++) sample(10'd300);
    sample(10'd460);
    idle(2);
    check("R3 floor zero", O_RUN);
    sample(10'd460);
    idle(1);
    check("R3 step count trip", O_OFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule